// File: doc/BRIEF.md
# Pipeline Interlock Hazard Detector

This block is the stall controller for an in-order pipeline with five stages: fetch, decode, register read, execute and writeback. Each cycle it looks at the instruction waiting in register read. It checks that instruction's operand and result register ids against the older instructions that are still executing or writing back. When any conflict is found, it asserts `stall`. The stall freezes the register-read, decode and fetch stages, and an empty slot goes into execute in place of the waiting instruction.

The block keeps its own record of the instructions in flight. Each execution unit holds one countdown slot, loaded with the instruction's execute latency (one to six cycles) when the instruction issues. A single stage register models writeback. A shift register of future writeback-port bookings sits alongside these. Four conditions can hold an instruction back:

- a read-after-write match;
- a write-after-write match, but only where the older instruction would otherwise finish after the younger one;
- a busy execution unit;
- a writeback port that is already taken in the cycle the instruction would need it.

Write-after-read never holds anything back.

Top module: `pipe_interlock`

## Requirements
- R1: After reset nothing is in flight. With `rr_valid` low, `stall` is 0 and `ex_bubble` is 1, and the first valid instruction issues without a stall.
- R2: `stall` is 1 while a used source id (A or B) equals the result id of a valid instruction in an execute slot.
- R3: The read-after-write check also covers the instruction in writeback. A consumer can issue no earlier than the cycle after its producer's writeback cycle.
- R4: A source with its valid bit at 0, or an older instruction whose result-valid bit is 0, never takes part in a comparison.
- R5: A result-id match with an instruction in an execute slot stalls only while that instruction's remaining execute cycles (counting the current cycle) exceed the new instruction's latency `rr_lat`. Legal latencies are 1 to 6.
- R6: A new result id that equals only a source id of an older instruction causes no stall.
- R7: An instruction stalls while its unit (`rr_unit`, 0 or 1) holds an instruction with more than one execute cycle left. The units are not pipelined.
- R8: An instruction that issues in cycle t with latency L writes back in cycle t+L+1. It stalls if another in-flight instruction already holds that writeback cycle.
- R9: In every cycle where an instruction is held, `ex_bubble` is 1. In the cycle it issues, `ex_bubble` is 0 and `stall` is 0.
- R10: With `rr_valid` at 0, `stall` is 0 and `ex_bubble` is 1, whatever is in flight.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rr_valid | input | 1 | Register-read stage holds an instruction |
| rr_unit | input | UNIT_W | Execution unit the instruction needs |
| rr_lat | input | LAT_W | Execute latency in cycles, 1 to MAX_LAT |
| rr_src_a | input | REG_W | First source register id |
| rr_src_a_valid | input | 1 | First source is used |
| rr_src_b | input | REG_W | Second source register id |
| rr_src_b_valid | input | 1 | Second source is used |
| rr_dst | input | REG_W | Result register id |
| rr_dst_valid | input | 1 | Instruction writes a result |
| stall | output | 1 | Hold register-read, decode and fetch |
| ex_bubble | output | 1 | Execute receives an empty slot this cycle |

## Verification
Assertions check the following on every cycle:

- a unit slot is loaded only when it is free or finishing;
- a freshly loaded countdown equals the issued latency;
- at most one slot finishes per cycle;
- the writeback stage always agrees with the booking shift register.

The exact number of stall cycles can only be shown by the bench's scenarios. These cover a producer–consumer pair under every latency pair, unit pairing, issue gap and dependence kind. The bench also shows the write-after-write cutoff, the masking by valid bits, and the absence of any write-after-read stall.

// File: rtl/pipe_il_pkg.sv
// Package: shared types for the pipeline interlock.
// Assumes: nothing beyond IEEE 1800-2017.
package pipe_il_pkg;

    // One flag per kind of hazard seen by the register-read instruction.
    typedef struct packed {
        logic raw;
        logic waw;
        logic unit_busy;
        logic port_busy;
    } hz_cause_t;

    // True when any hazard flag is set.
    function automatic logic any_hazard(input hz_cause_t c);
        return c.raw | c.waw | c.unit_busy | c.port_busy;
    endfunction

endpackage

// File: rtl/il_exec_slot.sv
// Module: il_exec_slot
// Tracks the single instruction occupying one non-pipelined execution
// unit: its result id and a countdown of execute cycles left, counting
// the current one. Assumes load is only raised when the slot is free or
// its occupant is in its last execute cycle.
module il_exec_slot #(
    parameter int REG_W   = 5,
    parameter int MAX_LAT = 6,
    parameter int LAT_W   = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [REG_W-1:0] ld_dst,
    input  logic             ld_dst_valid,
    input  logic [LAT_W-1:0] ld_lat,
    output logic             valid,
    output logic [REG_W-1:0] dst,
    output logic             dst_valid,
    output logic [LAT_W-1:0] rem,
    output logic             busy,
    output logic             done
);

    // Load a new occupant or count the current one down.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid     <= 1'b0;
            dst       <= '0;
            dst_valid <= 1'b0;
            rem       <= '0;
        end else if (load) begin
            valid     <= 1'b1;
            dst       <= ld_dst;
            dst_valid <= ld_dst_valid;
            rem       <= ld_lat;
        end else if (valid) begin
            if (rem == LAT_W'(1)) begin
                valid <= 1'b0;
                rem   <= '0;
            end else begin
                rem <= rem - LAT_W'(1);
            end
        end
    end

    // Occupancy flags seen by the comparator and the writeback stage.
    always_comb begin
        busy = valid && (rem > LAT_W'(1));
        done = valid && (rem == LAT_W'(1));
    end

    // R7: the unit is never reloaded while its occupant still needs it.
    p_load_when_free_r7: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (!valid || rem == LAT_W'(1)));

    // R5: a freshly loaded countdown equals the issued latency.
    p_load_rem_r5: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (valid && rem == $past(ld_lat)));

    // R5: an occupied slot always holds a legal countdown.
    p_rem_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> (rem != '0 && rem <= LAT_W'(MAX_LAT)));

endmodule

// File: rtl/il_wb_reserve.sv
// Module: il_wb_reserve
// Books the writeback port ahead of time. Bit k set means a writeback
// happens k cycles from now (bit 0 is the current cycle). Assumes every
// issued instruction writes back exactly lat+1 cycles after issue.
module il_wb_reserve #(
    parameter int MAX_LAT = 6,
    parameter int LAT_W   = 3,
    parameter int RES_W   = MAX_LAT + 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             issue,
    input  logic [LAT_W-1:0] lat,
    output logic [RES_W-1:0] res
);

    logic [RES_W-1:0] res_next;

    // Age every booking by one cycle and add the new issue's slot.
    always_comb begin
        for (int k = 0; k < RES_W; k++) begin
            res_next[k] = (k + 1 < RES_W) ? res[(k + 1) % RES_W] : 1'b0;
            if (issue && k == int'(lat)) begin
                res_next[k] = 1'b1;
            end
        end
    end

    // Booking register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res <= '0;
        end else begin
            res <= res_next;
        end
    end

    // R8: a new booking never lands on an already booked cycle.
    p_no_double_book_r8: assert property (@(posedge clk) disable iff (!rst_n)
        issue |=> $countones(res) == $countones($past(res) >> 1) + 1);

endmodule

// File: rtl/il_hazard_cmp.sv
// Module: il_hazard_cmp
// Compares the register-read instruction against the execute slots,
// the writeback stage and the port bookings, and reports each hazard
// kind. Purely combinational. Assumes rr_lat is in 1..MAX_LAT.
module il_hazard_cmp
    import pipe_il_pkg::*;
#(
    parameter int REG_W     = 5,
    parameter int LAT_W     = 3,
    parameter int NUM_UNITS = 2,
    parameter int UNIT_W    = 1,
    parameter int RES_W     = 8
) (
    input  logic [UNIT_W-1:0]               rr_unit,
    input  logic [LAT_W-1:0]                rr_lat,
    input  logic [REG_W-1:0]                rr_src_a,
    input  logic                            rr_src_a_valid,
    input  logic [REG_W-1:0]                rr_src_b,
    input  logic                            rr_src_b_valid,
    input  logic [REG_W-1:0]                rr_dst,
    input  logic                            rr_dst_valid,
    input  logic [NUM_UNITS-1:0]            slot_valid,
    input  logic [NUM_UNITS-1:0][REG_W-1:0] slot_dst,
    input  logic [NUM_UNITS-1:0]            slot_dst_valid,
    input  logic [NUM_UNITS-1:0][LAT_W-1:0] slot_rem,
    input  logic [NUM_UNITS-1:0]            slot_busy,
    input  logic                            wb_valid,
    input  logic [REG_W-1:0]                wb_dst,
    input  logic                            wb_dst_valid,
    input  logic [RES_W-1:0]                res,
    output hz_cause_t                       cause
);

    // Match the operands against every older instruction.
    always_comb begin
        cause = '0;
        for (int u = 0; u < NUM_UNITS; u++) begin
            if (slot_valid[u] && slot_dst_valid[u]) begin
                if (rr_src_a_valid && slot_dst[u] == rr_src_a) cause.raw = 1'b1;
                if (rr_src_b_valid && slot_dst[u] == rr_src_b) cause.raw = 1'b1;
                if (rr_dst_valid && slot_dst[u] == rr_dst && slot_rem[u] > rr_lat)
                    cause.waw = 1'b1;
            end
            if (slot_busy[u] && rr_unit == UNIT_W'(u)) cause.unit_busy = 1'b1;
        end
        if (wb_valid && wb_dst_valid) begin
            if (rr_src_a_valid && wb_dst == rr_src_a) cause.raw = 1'b1;
            if (rr_src_b_valid && wb_dst == rr_src_b) cause.raw = 1'b1;
        end
        for (int k = 0; k < RES_W; k++) begin
            if (res[k] && k == int'(rr_lat) + 1) cause.port_busy = 1'b1;
        end
    end

endmodule

// File: rtl/pipe_interlock.sv
// Module: pipe_interlock
// Stall controller for an in-order five-stage pipeline. Holds the
// register-read instruction (and, through stall, decode and fetch) on a
// data, unit or writeback-port hazard and sends an empty slot into
// execute. Assumes the upstream stages obey stall and that rr_lat is in
// 1..MAX_LAT whenever rr_valid is high.
module pipe_interlock
    import pipe_il_pkg::*;
#(
    parameter int REG_W     = 5,
    parameter int NUM_UNITS = 2,
    parameter int MAX_LAT   = 6,
    parameter int LAT_W     = $clog2(MAX_LAT + 1),
    parameter int UNIT_W    = (NUM_UNITS > 1) ? $clog2(NUM_UNITS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rr_valid,
    input  logic [UNIT_W-1:0] rr_unit,
    input  logic [LAT_W-1:0]  rr_lat,
    input  logic [REG_W-1:0]  rr_src_a,
    input  logic              rr_src_a_valid,
    input  logic [REG_W-1:0]  rr_src_b,
    input  logic              rr_src_b_valid,
    input  logic [REG_W-1:0]  rr_dst,
    input  logic              rr_dst_valid,
    output logic              stall,
    output logic              ex_bubble
);

    localparam int RES_W = MAX_LAT + 2;

    logic [NUM_UNITS-1:0]            slot_valid;
    logic [NUM_UNITS-1:0][REG_W-1:0] slot_dst;
    logic [NUM_UNITS-1:0]            slot_dst_valid;
    logic [NUM_UNITS-1:0][LAT_W-1:0] slot_rem;
    logic [NUM_UNITS-1:0]            slot_busy;
    logic [NUM_UNITS-1:0]            slot_done;
    logic [NUM_UNITS-1:0]            slot_load;
    logic                            wb_valid;
    logic [REG_W-1:0]                wb_dst;
    logic                            wb_dst_valid;
    logic [REG_W-1:0]                wb_dst_next;
    logic                            wb_dv_next;
    logic [RES_W-1:0]                res;
    hz_cause_t                       cause;
    logic                            issue;

    // Issue when a valid instruction sees no hazard.
    always_comb begin
        issue     = rr_valid && !any_hazard(cause);
        stall     = rr_valid && any_hazard(cause);
        ex_bubble = !issue;
    end

    // One countdown slot per execution unit.
    for (genvar g = 0; g < NUM_UNITS; g++) begin : g_unit
        assign slot_load[g] = issue && (rr_unit == UNIT_W'(g));
        il_exec_slot #(
            .REG_W   (REG_W),
            .MAX_LAT (MAX_LAT),
            .LAT_W   (LAT_W)
        ) u_slot (
            .clk          (clk),
            .rst_n        (rst_n),
            .load         (slot_load[g]),
            .ld_dst       (rr_dst),
            .ld_dst_valid (rr_dst_valid),
            .ld_lat       (rr_lat),
            .valid        (slot_valid[g]),
            .dst          (slot_dst[g]),
            .dst_valid    (slot_dst_valid[g]),
            .rem          (slot_rem[g]),
            .busy         (slot_busy[g]),
            .done         (slot_done[g])
        );
    end

    // Select the slot that finishes execute this cycle.
    always_comb begin
        wb_dst_next = '0;
        wb_dv_next  = 1'b0;
        for (int u = 0; u < NUM_UNITS; u++) begin
            if (slot_done[u]) begin
                wb_dst_next = wb_dst_next | slot_dst[u];
                wb_dv_next  = wb_dv_next | slot_dst_valid[u];
            end
        end
    end

    // Writeback stage register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wb_valid     <= 1'b0;
            wb_dst       <= '0;
            wb_dst_valid <= 1'b0;
        end else begin
            wb_valid     <= |slot_done;
            wb_dst       <= wb_dst_next;
            wb_dst_valid <= wb_dv_next;
        end
    end

    il_wb_reserve #(
        .MAX_LAT (MAX_LAT),
        .LAT_W   (LAT_W),
        .RES_W   (RES_W)
    ) u_reserve (
        .clk   (clk),
        .rst_n (rst_n),
        .issue (issue),
        .lat   (rr_lat),
        .res   (res)
    );

    il_hazard_cmp #(
        .REG_W     (REG_W),
        .LAT_W     (LAT_W),
        .NUM_UNITS (NUM_UNITS),
        .UNIT_W    (UNIT_W),
        .RES_W     (RES_W)
    ) u_cmp (
        .rr_unit        (rr_unit),
        .rr_lat         (rr_lat),
        .rr_src_a       (rr_src_a),
        .rr_src_a_valid (rr_src_a_valid),
        .rr_src_b       (rr_src_b),
        .rr_src_b_valid (rr_src_b_valid),
        .rr_dst         (rr_dst),
        .rr_dst_valid   (rr_dst_valid),
        .slot_valid     (slot_valid),
        .slot_dst       (slot_dst),
        .slot_dst_valid (slot_dst_valid),
        .slot_rem       (slot_rem),
        .slot_busy      (slot_busy),
        .wb_valid       (wb_valid),
        .wb_dst         (wb_dst),
        .wb_dst_valid   (wb_dst_valid),
        .res            (res),
        .cause          (cause)
    );

    // R8: the writeback stage and the port bookings never disagree.
    p_wb_tracks_reserve_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid == res[0]);

    // R8: at most one unit hands over to writeback per cycle.
    p_single_writer_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(slot_done));

    // R5: a presented instruction carries a legal latency.
    p_lat_legal_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rr_valid |-> (rr_lat != '0 && rr_lat <= LAT_W'(MAX_LAT)));

endmodule

// File: tb/sim_pipe_interlock.sv
`timescale 1ns/1ps
// Bench: sweeps producer/consumer pairs over every latency pair, unit
// pairing, issue gap and dependence kind. Expected stall counts are
// worked out from the timing rules in the requirements.
module sim_pipe_interlock;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rr_valid = 1'b0;
    logic [0:0] rr_unit = '0;
    logic [2:0] rr_lat = 3'd1;
    logic [4:0] rr_src_a = '0;
    logic       rr_src_a_valid = 1'b0;
    logic [4:0] rr_src_b = '0;
    logic       rr_src_b_valid = 1'b0;
    logic [4:0] rr_dst = '0;
    logic       rr_dst_valid = 1'b0;
    logic       stall;
    logic       ex_bubble;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    pipe_interlock u0 (
        .clk(clk), .rst_n(rst_n), .rr_valid(rr_valid), .rr_unit(rr_unit),
        .rr_lat(rr_lat), .rr_src_a(rr_src_a), .rr_src_a_valid(rr_src_a_valid),
        .rr_src_b(rr_src_b), .rr_src_b_valid(rr_src_b_valid), .rr_dst(rr_dst),
        .rr_dst_valid(rr_dst_valid), .stall(stall), .ex_bubble(ex_bubble)
    );

    task automatic check(input string tag, input string ctx, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, ctx, act, exp);
        end
    endtask

    task automatic drive(input bit v, input int unit, input int lat,
                         input int sa, input bit sav, input int sb, input bit sbv,
                         input int d, input bit dv);
        rr_valid = v; rr_unit = 1'(unit); rr_lat = 3'(lat);
        rr_src_a = 5'(sa); rr_src_a_valid = sav;
        rr_src_b = 5'(sb); rr_src_b_valid = sbv;
        rr_dst = 5'(d); rr_dst_valid = dv;
    endtask

    // Producer presented at cycle 0 and issues there; consumer presented at t1.
    function automatic int exp_wait(int lp, int lc, bit same, int k, int t1);
        bit raw = (k == 1 || k == 2);
        bit waw = (k == 3);
        for (int c = t1; c < t1 + 40; c++) begin
            bit haz = 0;
            if (raw && c <= lp + 1) haz = 1;                       // R2, R3
            if (waw && c <= lp && (lp - c + 1) > lc) haz = 1;      // R5
            if (same && c <= lp - 1) haz = 1;                      // R7
            if (c + 1 + lc == lp + 1) haz = 1;                     // R8
            if (!haz) return c - t1;
        end
        return -1;
    endfunction

    task automatic run(input int lp, input int lc, input bit same, input int k, input int gap);
        string ctx = $sformatf("lp=%0d lc=%0d same=%0d kind=%0d gap=%0d", lp, lc, same, k, gap);
        string tag;
        int ca = 4, cb = 5, cd = 6;
        bit cav = 1, pdv = 1;
        int waits = 0;
        int expw;
        case (k)
            1: ca = 3;
            2: cb = 3;
            3: cd = 3;
            4: cd = 1;
            5: begin ca = 3; cav = 0; end
            6: begin pdv = 0; ca = 3; cd = 3; end
            default: ;
        endcase
        case (k)
            0: tag = same ? "R7" : "R8";
            1, 2: tag = "R2,R3";
            3: tag = "R5";
            4: tag = "R6";
            default: tag = "R4";
        endcase
        // Producer on unit 0: sources 1 and 2, result 3.
        @(negedge clk);
        drive(1, 0, lp, 1, 1, 2, 1, 3, pdv);
        #2;
        check("R1", ctx, int'(stall), 0);
        for (int g = 0; g < gap; g++) begin
            @(negedge clk);
            drive(0, 0, 1, 0, 0, 0, 0, 0, 0);
            #2;
            check("R10", ctx, int'({stall, ex_bubble}), 1);
        end
        @(negedge clk);
        drive(1, same ? 0 : 1, lc, ca, cav, cb, 1, cd, 1);
        forever begin
            #2;
            check("R9", ctx, int'(ex_bubble), int'(stall));
            if (!stall || waits > 30) break;
            waits++;
            @(negedge clk);
        end
        expw = exp_wait(lp, lc, same, k, 1 + gap);
        check(tag, ctx, waits, expw);
        @(negedge clk);
        drive(0, 0, 1, 0, 0, 0, 0, 0, 0);
        repeat (10) @(negedge clk);
    endtask

    initial begin
        #(8 * 150000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #2;
        check("R1", "after reset stall", int'(stall), 0);
        check("R1", "after reset bubble", int'(ex_bubble), 1);
        for (int k = 0; k < 7; k++)
            for (int lp = 1; lp <= 6; lp++)
                for (int lc = 1; lc <= 6; lc++)
                    for (int s = 0; s < 2; s++)
                        for (int gap = 0; gap < 3; gap++)
                            run(lp, lc, s[0], k, gap);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule